// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit forms the 32-bit effective address used by a simple RISC pipeline for loads, stores, branch targets and sequential instruction fetch. A three-bit mode input picks how the address is formed. The data modes are base plus sign-extended immediate, base plus index register, and register alone. The branch modes are displacement (relative or absolute), link-register indirect and count-register indirect. One further mode produces the next sequential fetch address. Every path goes through a single adder that works modulo 2^32, so a sum past the top of the address space wraps through zero instead of raising a fault.

For data modes the unit also reports whether the result is misaligned for the given operand size. An operand is misaligned when its address is not a whole multiple of its length. Results are registered, with one cycle of latency, under a simple valid handshake.

Top module: `ea_gen_unit`

## Requirements
- R1: Mode 0 (immediate data) gives base + imm modulo 2^32, where base is rs_a, or zero when ra_idx is 0.
- R2: Mode 1 (indexed data) gives base + rs_b modulo 2^32, with the same rule that base is zero when ra_idx is 0.
- R3: Mode 2 (register data) gives rs_a unchanged, and ra_idx has no effect in this mode.
- R4: Any sum above 2^32-1 wraps: the carry out of bit 31 is discarded and ea holds the low 32 bits.
- R5: In mode 3 with abs_flag low, ea is cur_pc + (disp sign-extended and shifted left by 2), modulo 2^32.
- R6: In mode 3 with abs_flag high, ea is disp sign-extended and shifted left by 2, and cur_pc has no effect.
- R7: Mode 4 gives lr and mode 5 gives ctr, each with bits 1:0 forced to 0.
- R8: Modes 6 and 7 give the sequential fetch address cur_pc + 4, modulo 2^32.
- R9: In modes 0 to 2, op_size 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. misaligned is 1 exactly when the low 0, 1, 2 or 3 bits of ea (respectively) are not all zero.
- R10: In modes 3 to 7, misaligned is 0.
- R11: out_valid equals in_valid from the previous cycle. ea and misaligned are updated only in a cycle after in_valid was high, and otherwise hold their values.
- R12: While rst_n is sampled low at a clock edge, out_valid, ea and misaligned become 0, whatever in_valid is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request valid this cycle |
| mode | input | 3 | Address mode select (0..7) |
| ra_idx | input | 5 | Base register index; 0 selects a zero base in modes 0 and 1 |
| rs_a | input | 32 | Base register value |
| rs_b | input | 32 | Index register value |
| imm | input | 32 | Sign-extended data immediate |
| disp | input | 24 | Word displacement for branches |
| abs_flag | input | 1 | Absolute branch target select |
| cur_pc | input | 32 | Current instruction address |
| lr | input | 32 | Link register value |
| ctr | input | 32 | Count register value |
| op_size | input | 2 | Operand size code (1/2/4/8 bytes) |
| out_valid | output | 1 | Result valid |
| ea | output | 32 | Effective address |
| misaligned | output | 1 | Operand not naturally aligned |

## Verification
The sweep crosses every mode with every size code and sixteen low-address offsets. It uses bases close to 2^32, so sums with a carry out of bit 31 show up in data, relative-branch and sequential paths. A unit that kept the carry, or one that faulted, would give a wrong low word. A zero base index is mixed in to catch a design that adds rs_a when register 0 is selected, and to catch a register-only mode that wrongly applies that rule. Negative displacements test the sign extension and the shift by two. Low bits set in lr and ctr show whether they are cleared. Each size code is checked against every offset, which catches a mask off by one bit. Idle cycles with changed inputs, and a reset applied with in_valid high, catch outputs that change without a request.

// File: rtl/eag_pkg.sv
// Package: shared mode encoding for the effective address generation unit.
// Assumes: the mode field is three bits wide and encodings 6 and 7 both select sequential fetch.
package eag_pkg;

    typedef enum logic [2:0] {
        MODE_D_IMM  = 3'd0,
        MODE_D_IDX  = 3'd1,
        MODE_D_REG  = 3'd2,
        MODE_B_DISP = 3'd3,
        MODE_B_LR   = 3'd4,
        MODE_B_CTR  = 3'd5,
        MODE_SEQ    = 3'd6,
        MODE_SEQ_RS = 3'd7
    } ea_mode_e;

    localparam int INSN_BYTES = 4;

endpackage

// File: rtl/eag_operand_sel.sv
// Module: picks the two adder operands for each mode and says whether the
// result is a data address and whether its low two bits must be cleared.
// Assumes: ADDR_W >= DISP_W + 2; imm is already sign-extended by the decoder.
module eag_operand_sel
    import eag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 24,
    parameter int RIDX_W = 5
) (
    input  logic [2:0]        mode,
    input  logic [RIDX_W-1:0] ra_idx,
    input  logic [ADDR_W-1:0] rs_a,
    input  logic [ADDR_W-1:0] rs_b,
    input  logic [ADDR_W-1:0] imm,
    input  logic [DISP_W-1:0] disp,
    input  logic              abs_flag,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [ADDR_W-1:0] lr,
    input  logic [ADDR_W-1:0] ctr,
    output logic [ADDR_W-1:0] opnd_x,
    output logic [ADDR_W-1:0] opnd_y,
    output logic              clr_low2,
    output logic              is_data
);

    localparam int EXT_W = ADDR_W - DISP_W - 2;

    logic [ADDR_W-1:0] base_or_zero;
    logic [ADDR_W-1:0] disp_bytes;
    ea_mode_e          mode_e;

    assign mode_e       = ea_mode_e'(mode);
    assign base_or_zero = (ra_idx == '0) ? '0 : rs_a;
    assign disp_bytes   = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};

    // Operand routing per address mode.
    always_comb begin
        opnd_x   = '0;
        opnd_y   = '0;
        clr_low2 = 1'b0;
        is_data  = 1'b0;
        unique case (mode_e)
            MODE_D_IMM: begin
                opnd_x  = base_or_zero;
                opnd_y  = imm;
                is_data = 1'b1;
            end
            MODE_D_IDX: begin
                opnd_x  = base_or_zero;
                opnd_y  = rs_b;
                is_data = 1'b1;
            end
            MODE_D_REG: begin
                opnd_x  = rs_a;
                is_data = 1'b1;
            end
            MODE_B_DISP: begin
                opnd_x = abs_flag ? '0 : cur_pc;
                opnd_y = disp_bytes;
            end
            MODE_B_LR: begin
                opnd_x   = lr;
                clr_low2 = 1'b1;
            end
            MODE_B_CTR: begin
                opnd_x   = ctr;
                clr_low2 = 1'b1;
            end
            default: begin
                opnd_x = cur_pc;
                opnd_y = ADDR_W'(INSN_BYTES);
            end
        endcase
    end

endmodule

// File: rtl/eag_wrap_adder.sv
// Module: W-bit ripple adder whose carry out of the top bit is dropped,
// giving modulo-2^W arithmetic.
// Assumes: W >= 2.
module eag_wrap_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);

    logic [W-1:0] carry;

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i] = a[i] ^ b[i] ^ carry[i];
        if (i < W - 1) begin : g_carry
            assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
        end
    end

endmodule

// File: rtl/eag_align_check.sv
// Module: flags an address that is not a multiple of the operand length
// 2**size_code bytes, but only when the check is enabled.
// Assumes: 2**SIZE_W - 1 < ADDR_W.
module eag_align_check #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size_code,
    input  logic              enable,
    output logic              misaligned
);

    localparam int NSIZES = 1 << SIZE_W;

    logic [NSIZES-1:0] bad_for_size;

    for (genvar g = 0; g < NSIZES; g++) begin : g_size
        localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << g) - ADDR_W'(1);
        assign bad_for_size[g] = |(addr & LOW_MASK);
    end

    assign misaligned = enable & bad_for_size[size_code];

endmodule

// File: rtl/ea_gen_unit.sv
// Module: top of the effective address generation unit. Selects operands,
// adds them modulo 2^ADDR_W, clears the low bits of register-indirect branch
// targets, checks alignment and registers the result with one cycle of latency.
// Assumes: synchronous active-low reset; the outputs hold while no request arrives.
module ea_gen_unit
    import eag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 24,
    parameter int RIDX_W = 5,
    parameter int SIZE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        mode,
    input  logic [RIDX_W-1:0] ra_idx,
    input  logic [ADDR_W-1:0] rs_a,
    input  logic [ADDR_W-1:0] rs_b,
    input  logic [ADDR_W-1:0] imm,
    input  logic [DISP_W-1:0] disp,
    input  logic              abs_flag,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [ADDR_W-1:0] lr,
    input  logic [ADDR_W-1:0] ctr,
    input  logic [SIZE_W-1:0] op_size,
    output logic              out_valid,
    output logic [ADDR_W-1:0] ea,
    output logic              misaligned
);

    logic [ADDR_W-1:0] opnd_x;
    logic [ADDR_W-1:0] opnd_y;
    logic [ADDR_W-1:0] raw_sum;
    logic [ADDR_W-1:0] ea_next;
    logic              clr_low2;
    logic              is_data;
    logic              mis_next;

    eag_operand_sel #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W),
        .RIDX_W (RIDX_W)
    ) u_sel (
        .mode     (mode),
        .ra_idx   (ra_idx),
        .rs_a     (rs_a),
        .rs_b     (rs_b),
        .imm      (imm),
        .disp     (disp),
        .abs_flag (abs_flag),
        .cur_pc   (cur_pc),
        .lr       (lr),
        .ctr      (ctr),
        .opnd_x   (opnd_x),
        .opnd_y   (opnd_y),
        .clr_low2 (clr_low2),
        .is_data  (is_data)
    );

    eag_wrap_adder #(
        .W (ADDR_W)
    ) u_add (
        .a   (opnd_x),
        .b   (opnd_y),
        .sum (raw_sum)
    );

    // Force word alignment of register-indirect branch targets.
    always_comb begin
        ea_next = raw_sum;
        if (clr_low2) begin
            ea_next[1:0] = 2'b00;
        end
    end

    eag_align_check #(
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W)
    ) u_align (
        .addr       (ea_next),
        .size_code  (op_size),
        .enable     (is_data),
        .misaligned (mis_next)
    );

    // Output register: capture on a request, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            ea         <= '0;
            misaligned <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                ea         <= ea_next;
                misaligned <= mis_next;
            end
        end
    end

endmodule

// File: rtl/eag_checker.sv
// Module: property checker for ea_gen_unit, attached by bind below.
// Assumes: the same parameter values as the unit it watches.
module eag_checker #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        mode,
    input logic [ADDR_W-1:0] cur_pc,
    input logic [SIZE_W-1:0] op_size,
    input logic              out_valid,
    input logic [ADDR_W-1:0] ea,
    input logic              misaligned
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                                  // R11
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                                // R11
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && rst_n) |=> ($stable(ea) && $stable(misaligned)));           // R11
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && ea == '0 && !misaligned));                      // R12
    AST_INDIRECT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode == 3'd4 || mode == 3'd5)) |=> (ea[1:0] == 2'b00));     // R7
    AST_SEQ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode[2:1] == 2'b11) |=> (ea == $past(cur_pc) + ADDR_W'(4))); // R8
    AST_BRANCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode >= 3'd3) |=> !misaligned);                              // R10
    AST_BYTE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_size == '0) |=> !misaligned);                             // R9

endmodule

bind ea_gen_unit eag_checker #(
    .ADDR_W (ADDR_W),
    .SIZE_W (SIZE_W)
) u_eag_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .mode       (mode),
    .cur_pc     (cur_pc),
    .op_size    (op_size),
    .out_valid  (out_valid),
    .ea         (ea),
    .misaligned (misaligned)
);

// File: tb/ea_gen_unit_test.sv
`timescale 1ns/1ps
// Bench: sweeps every mode, size code and low-offset pattern, with expected
// addresses computed arithmetically in the bench.
module ea_gen_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic [4:0]  ra_idx = '0;
    logic [31:0] rs_a = '0, rs_b = '0, imm = '0, cur_pc = '0, lr = '0, ctr = '0;
    logic [23:0] disp = '0;
    logic        abs_flag = 1'b0;
    logic [1:0]  op_size = '0;
    logic        out_valid;
    logic [31:0] ea;
    logic        misaligned;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [31:0] lcg = 32'h1234_5678;

    always #4 clk = ~clk;

    ea_gen_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .ra_idx(ra_idx),
        .rs_a(rs_a), .rs_b(rs_b), .imm(imm), .disp(disp), .abs_flag(abs_flag),
        .cur_pc(cur_pc), .lr(lr), .ctr(ctr), .op_size(op_size),
        .out_valid(out_valid), .ea(ea), .misaligned(misaligned)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    // Expected address and carry flag from the requirement arithmetic.
    task automatic model(output logic [31:0] e_ea, output logic e_mis,
                         output logic carry, output string req);
        logic [32:0] s;
        logic [31:0] base, dsp;
        base = (ra_idx == 0) ? 32'd0 : rs_a;
        dsp  = {{6{disp[23]}}, disp, 2'b00};
        s = 33'd0;
        e_mis = 1'b0;
        case (mode)
            3'd0: begin s = {1'b0, base} + {1'b0, imm};  req = "R1"; end
            3'd1: begin s = {1'b0, base} + {1'b0, rs_b}; req = "R2"; end
            3'd2: begin s = {1'b0, rs_a};                req = "R3"; end
            3'd3: begin
                if (abs_flag) begin s = {1'b0, dsp}; req = "R6"; end
                else begin s = {1'b0, cur_pc} + {1'b0, dsp}; req = "R5"; end
            end
            3'd4: begin s = {1'b0, lr & 32'hFFFF_FFFC};  req = "R7"; end
            3'd5: begin s = {1'b0, ctr & 32'hFFFF_FFFC}; req = "R7"; end
            default: begin s = {1'b0, cur_pc} + 33'd4;   req = "R8"; end
        endcase
        e_ea = s[31:0];
        carry = s[32];
        if (mode <= 3'd2) e_mis = (e_ea % (32'd1 << op_size)) != 0;
    endtask

    initial begin
        logic [31:0] e_ea, last_ea;
        logic e_mis, carry, last_mis;
        string req;
        logic [31:0] bases [4];
        bases[0] = 32'h0000_1000; bases[1] = 32'hFFFF_FFF8;
        bases[2] = 32'h7FFF_FFF0; bases[3] = 32'h8000_0020;

        // R12: reset with in_valid high.
        in_valid = 1'b1; mode = 3'd6; cur_pc = 32'h0000_0100;
        repeat (3) @(negedge clk);
        check("R12 out_valid", {31'd0, out_valid}, 32'd0);
        check("R12 ea", ea, 32'd0);
        check("R12 misaligned", {31'd0, misaligned}, 32'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 idle after reset", {31'd0, out_valid}, 32'd0);

        for (int m = 0; m < 8; m++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int lo = 0; lo < 16; lo++) begin
                    mode = 3'(m); op_size = 2'(sz);
                    ra_idx = (lo % 4 == 0) ? 5'd0 : 5'(lo);
                    rs_a = bases[lo % 4] + 32'(lo);
                    rs_b = (lo % 2 == 1) ? 32'(lo + 8) : rnd();
                    imm  = (lo % 3 == 0) ? 32'hFFFF_FFF0 + 32'(lo) : 32'(lo * 3);
                    disp = (lo % 2 == 0) ? 24'hFFFFF0 + 24'(lo) : rnd()[23:0];
                    abs_flag = lo[2];
                    cur_pc = (lo % 4 == 1) ? 32'hFFFF_FFF0 + 32'(lo) : rnd();
                    lr  = rnd() | 32'(lo & 3);
                    ctr = rnd() | 32'(lo & 3);
                    in_valid = 1'b1;
                    model(e_ea, e_mis, carry, req);
                    @(negedge clk);
                    check("R11 out_valid", {31'd0, out_valid}, 32'd1);
                    check(carry ? "R4" : req, ea, e_ea);
                    check(m <= 2 ? "R9" : "R10", {31'd0, misaligned}, {31'd0, e_mis});
                    last_ea = e_ea; last_mis = e_mis;
                    // R11 and R3/R6: idle cycle with inputs changed.
                    if (lo == 5) begin
                        in_valid = 1'b0; rs_a = ~rs_a; cur_pc = ~cur_pc; mode = 3'd1;
                        @(negedge clk);
                        check("R11 idle valid", {31'd0, out_valid}, 32'd0);
                        check("R11 idle ea", ea, last_ea);
                        check("R11 idle mis", {31'd0, misaligned}, {31'd0, last_mis});
                    end
                end
            end
        end

        // R4: explicit wrap cases.
        in_valid = 1'b1; mode = 3'd0; ra_idx = 5'd3; rs_a = 32'hFFFF_FFFC; imm = 32'd8;
        op_size = 2'd2;
        @(negedge clk);
        check("R4 data wrap", ea, 32'd4);
        mode = 3'd6; cur_pc = 32'hFFFF_FFFC;
        @(negedge clk);
        check("R4 fetch wrap", ea, 32'd0);
        // R3: zero index ignored in register mode.
        mode = 3'd2; ra_idx = 5'd0; rs_a = 32'hABCD_0002; op_size = 2'd1;
        @(negedge clk);
        check("R3 ra_idx ignored", ea, 32'hABCD_0002);
        check("R9 halfword aligned", {31'd0, misaligned}, 32'd0);
        // R6: absolute ignores pc.
        mode = 3'd3; abs_flag = 1'b1; disp = 24'h800000; cur_pc = 32'h1234_5678;
        @(negedge clk);
        check("R6 absolute negative", ea, 32'hFE00_0000);
        // R12: reset mid-stream.
        rst_n = 1'b0;
        @(negedge clk);
        check("R12 mid reset valid", {31'd0, out_valid}, 32'd0);
        check("R12 mid reset ea", ea, 32'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule